// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire bus (clock line plus open-drain data line) that gives a host byte-wide read and write access to a bank of 23 configuration registers. The bus lines enter as plain inputs. The block pulls the data line low by raising an output-enable. The whole register bank is presented in parallel to the surrounding logic. A few bit positions are fixed identification or status bits. For those positions the register view takes its value from an input, and bus writes cannot change them.

Each transfer begins with the slave's write address byte and a command byte. A command below 128 names a starting register and requests the counted block form. In this form a byte count travels ahead of the data. A command with its top bit set names a register for a plain byte or word access, which has no count. Data always moves from the named register upward. A read repeats the start condition after the command and then sends the read address, and the slave returns the bytes. A STOP ends any transfer. A START begins a new one. Neither undoes a write that has already been acknowledged.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset every writable register bit reads 0, and the slave does not drive the data line.
- R2: The address byte 0xD2 (write) is acknowledged. Any other byte in the address position is not acknowledged, except as stated in R7 and R10.
- R3: Command values 0 to 22 are acknowledged and set the start register for a counted block write. The next byte is a count N. The N data bytes that follow go to consecutive registers in ascending order, and each one is acknowledged.
- R4: A command of 128 plus an index 0 to 22 selects a write with no count. The first data byte goes to that register, and a second data byte goes to the next register (word form).
- R5: A command whose low 7 bits exceed 22 is not acknowledged, and no register changes.
- R6: A data byte is not acknowledged and not written if it goes past register 22, goes past the block count, or is a third byte of the byte/word form. The transfer is then ignored until the next START or STOP.
- R7: For a block read, the host sends 0xD2, a command 0 to 22, a repeated START and 0xD3. The slave acknowledges and returns the count 23 minus the start index, followed by the registers in ascending order. Reads past register 22 return 0xFF.
- R8: After a command of 128 plus an index, a repeated START and 0xD3, the slave returns that register and then the registers above it, one per byte the host acknowledges. A host NACK ends the read.
- R9: The fixed bits are bits 3:0 of register 1 and all of register 8. In the register view and in readback they equal the matching bits of `stat_i`, and writes to them are ignored.
- R10: A STOP or START in the middle of a byte returns the slave to idle. Registers written before it are kept. 0xD3 is acknowledged only if a command byte has been accepted since the last STOP.
- R11: The slave changes its data-line enable only while the bus clock is low.

Register i occupies bits [8*i+7 : 8*i] of `cfg_o` and of `stat_i`. Bytes travel most significant bit first. An acknowledge is the data line held low during the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | When high, the slave pulls the data line low |
| stat_i | input | 184 | Values for the fixed bit positions, 8 bits per register |
| cfg_o | output | 184 | Register bank view, 8 bits per register |

## Verification
The checks assume the host holds every bus clock phase for much longer than the synchronizer delay and changes the data line only in the middle of a clock-low phase, except for START and STOP. They also assume the host never issues a STOP or START while the slave is driving an acknowledge or a data bit. The bench drives the lines from tasks that wait 20 system clocks per half bit. It sets data 10 cycles after each falling edge of the bus clock and issues START and STOP only after the slave has released the line. Under those conditions, an enable change while the bus clock is high, or a register write outside an acknowledge clock, points to a design fault and not to bad stimulus.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WCNT,
    ST_WDATA,
    ST_RCNT,
    ST_RDATA,
    ST_SKIP
  } smb_st_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= scl_i;
          sda_ff <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_ff <= '1;
          sda_ff <= '1;
        end else begin
          scl_ff <= {scl_ff[STAGES-2:0], scl_i};
          sda_ff <= {sda_ff[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int NREG = 23,
  parameter int IW = 5,
  parameter logic [NREG*8-1:0] RO_MASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [NREG*8-1:0] stat_i,
  output logic [NREG*8-1:0] view_o
);
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [7:0] FIXED = RO_MASK[g*8 +: 8];
      logic [7:0] store;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) store <= '0;
        else if (wr_en && wr_idx == IW'(g)) store <= wr_data & ~FIXED;
      assign view_o[g*8 +: 8] = (store & ~FIXED) | (stat_i[g*8 +: 8] & FIXED);
    end
  endgenerate
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_pkg::*;
#(
  parameter int NREG = 23,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] RO_MASK =
    ({{(NREG*8-8){1'b0}}, 8'hFF} << 64) | ({{(NREG*8-8){1'b0}}, 8'h0F} << 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [NREG*8-1:0] stat_i,
  output logic [NREG*8-1:0] cfg_o
);
  localparam int IW = $clog2(NREG + 1);
  localparam logic [IW-1:0] LAST = IW'(NREG);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  smb_st_e st;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg, tx_byte, remain;
  logic [IW-1:0] ptr, ptr_inc;
  logic          blk_form, cmd_ok, ack_q, ack_dec;
  logic          rx_mode, tx_mode;
  logic [7:0]    rd_cur, rd_nxt;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_regbank #(.NREG(NREG), .IW(IW), .RO_MASK(RO_MASK)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .stat_i(stat_i), .view_o(cfg_o)
  );

  assign rx_mode = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_WCNT) || (st == ST_WDATA);
  assign tx_mode = (st == ST_RCNT) || (st == ST_RDATA);

  always_comb begin
    ptr_inc = (ptr < LAST) ? ptr + 1'b1 : ptr;
    rd_cur  = (ptr < LAST) ? cfg_o[int'(ptr)*8 +: 8] : 8'hFF;
    rd_nxt  = (ptr_inc < LAST) ? cfg_o[int'(ptr_inc)*8 +: 8] : 8'hFF;
  end

  // acknowledge decision for the byte just shifted in
  always_comb begin
    ack_dec = 1'b0;
    case (st)
      ST_ADDR:  ack_dec = (shreg == {DEV_ADDR, 1'b0}) ||
                          ((shreg == {DEV_ADDR, 1'b1}) && cmd_ok);
      ST_CMD:   ack_dec = (shreg[6:0] < 7'(NREG));
      ST_WCNT:  ack_dec = 1'b1;
      ST_WDATA: ack_dec = (remain != 8'd0) && (ptr < LAST);
      default:  ack_dec = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_byte  <= '0;
      remain   <= '0;
      ptr      <= '0;
      blk_form <= 1'b0;
      cmd_ok   <= 1'b0;
      ack_q    <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st       <= ST_IDLE;
        cmd_ok   <= 1'b0;
        sda_oe_o <= 1'b0;
        bit_cnt  <= '0;
      end else if (start_det) begin
        st       <= ST_ADDR;
        sda_oe_o <= 1'b0;
        bit_cnt  <= '0;
        ack_q    <= 1'b0;
      end else if (scl_rise && (rx_mode || tx_mode)) begin
        if (bit_cnt != 4'd8) begin
          if (rx_mode) shreg <= {shreg[6:0], sda_s};
          bit_cnt <= bit_cnt + 4'd1;
        end else begin
          bit_cnt <= '0;
          if (rx_mode) begin
            if (!ack_q) st <= ST_SKIP;
            else begin
              case (st)
                ST_ADDR: begin
                  if (shreg[0]) begin
                    if (blk_form) begin
                      st      <= ST_RCNT;
                      tx_byte <= 8'(NREG) - 8'(ptr);
                    end else begin
                      st      <= ST_RDATA;
                      tx_byte <= rd_cur;
                    end
                  end else st <= ST_CMD;
                end
                ST_CMD: begin
                  ptr      <= shreg[IW-1:0];
                  blk_form <= ~shreg[7];
                  cmd_ok   <= 1'b1;
                  if (shreg[7]) begin
                    st     <= ST_WDATA;
                    remain <= 8'd2;
                  end else st <= ST_WCNT;
                end
                ST_WCNT: begin
                  remain <= shreg;
                  st     <= ST_WDATA;
                end
                ST_WDATA: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= shreg;
                  ptr     <= ptr_inc;
                  remain  <= remain - 8'd1;
                end
                default: st <= ST_SKIP;
              endcase
            end
          end else begin
            // host acknowledge of a transmitted byte
            if (sda_s) st <= ST_SKIP;
            else if (st == ST_RCNT) begin
              st      <= ST_RDATA;
              tx_byte <= rd_cur;
            end else begin
              ptr     <= ptr_inc;
              tx_byte <= rd_nxt;
            end
          end
        end
      end else if (scl_fall) begin
        if (rx_mode && bit_cnt == 4'd8) begin
          sda_oe_o <= ack_dec;
          ack_q    <= ack_dec;
        end else if (tx_mode && bit_cnt != 4'd8) begin
          sda_oe_o <= ~tx_byte[3'd7 - bit_cnt[2:0]];
        end else begin
          sda_oe_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk #(
  parameter int NREG = 23,
  parameter int IW = 5,
  parameter logic [NREG*8-1:0] RO_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [NREG*8-1:0] stat_i,
  input logic [NREG*8-1:0] cfg_o,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx
);
  localparam logic [NREG*8-1:0] WMASK = ~RO_MASK;

  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_i);

  p_fixed_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_o & RO_MASK) == (stat_i & RO_MASK));

  p_wr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IW'(NREG)));

  p_wr_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(sda_oe_o));

  p_cfg_change_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o & WMASK) |-> scl_i);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NREG(NREG), .IW(IW), .RO_MASK(RO_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .stat_i(stat_i), .cfg_o(cfg_o), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/sim_smb_cfg_slave.sv
`timescale 1ns/1ps
module sim_smb_cfg_slave;
  localparam int NREG = 23;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_low = 1'b0;
  logic sda_oe;
  logic sda;
  logic [NREG*8-1:0] stat = '0;
  logic [NREG*8-1:0] cfg;

  int checks = 0;
  int errors = 0;
  int hi_changes = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign sda = ~(host_low | sda_oe);

  smb_cfg_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .sda_oe_o(sda_oe), .stat_i(stat), .cfg_o(cfg)
  );

  // R11 monitor: enable must not move while the bus clock is high
  always @(negedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && scl) hi_changes++;
    oe_prev <= sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return cfg[i*8 +: 8];
  endfunction

  task automatic bus_start;
    host_low = 1'b0; tick(H/2);
    scl = 1'b1;      tick(H);
    host_low = 1'b1; tick(H);
    scl = 1'b0;      tick(H/2);
  endtask

  task automatic bus_stop;
    host_low = 1'b1; tick(H/2);
    scl = 1'b1;      tick(H);
    host_low = 1'b0; tick(H);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    host_low = ~b; tick(H/2);
    scl = 1'b1;    tick(H/2);
    s = sda;       tick(H/2);
    scl = 1'b0;    tick(H/2);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      d[i] = s;
    end
    bit_cycle(~give_ack, s);
  endtask

  task automatic t_reset;
    check("R1 oe after reset", {31'd0, sda_oe}, 32'd0);
    check("R1 reg0", {24'd0, reg_of(0)}, 32'h00);
    check("R1 reg3", {24'd0, reg_of(3)}, 32'h00);
    check("R1 reg1 writable bits", {24'd0, reg_of(1)}, 32'h06);
    check("R9 reg8 fixed", {24'd0, reg_of(8)}, 32'h5A);
  endtask

  task automatic t_byte_write;
    logic a;
    bus_start;
    wbyte(8'hD2, a); check("R2 write address ack", {31'd0, a}, 32'd1);
    wbyte(8'd131, a); check("R4 byte command ack", {31'd0, a}, 32'd1);
    wbyte(8'hA5, a); check("R4 byte data ack", {31'd0, a}, 32'd1);
    bus_stop;
    check("R4 reg3 written", {24'd0, reg_of(3)}, 32'hA5);
  endtask

  task automatic t_bad_addr;
    logic a;
    bus_start;
    wbyte(8'hA4, a); check("R2 foreign address nack", {31'd0, a}, 32'd0);
    wbyte(8'd131, a);
    wbyte(8'h00, a);
    bus_stop;
    check("R2 reg3 untouched", {24'd0, reg_of(3)}, 32'hA5);
  endtask

  task automatic t_block_write;
    logic a;
    logic [7:0] v [3] = '{8'h11, 8'h22, 8'h33};
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd5, a);
    check("R3 block command ack", {31'd0, a}, 32'd1);
    wbyte(8'd3, a);
    for (int i = 0; i < 3; i++) begin
      wbyte(v[i], a); check("R3 block data ack", {31'd0, a}, 32'd1);
    end
    bus_stop;
    check("R3 reg5", {24'd0, reg_of(5)}, 32'h11);
    check("R3 reg6", {24'd0, reg_of(6)}, 32'h22);
    check("R3 reg7", {24'd0, reg_of(7)}, 32'h33);
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd12, a); wbyte(8'd1, a);
    wbyte(8'h44, a); check("R3 counted byte ack", {31'd0, a}, 32'd1);
    wbyte(8'h55, a); check("R6 byte past count nack", {31'd0, a}, 32'd0);
    bus_stop;
    check("R3 reg12", {24'd0, reg_of(12)}, 32'h44);
    check("R6 reg13 untouched", {24'd0, reg_of(13)}, 32'h00);
  endtask

  task automatic t_word_write;
    logic a;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd138, a);
    wbyte(8'h12, a); check("R4 word first ack", {31'd0, a}, 32'd1);
    wbyte(8'h34, a); check("R4 word second ack", {31'd0, a}, 32'd1);
    wbyte(8'h99, a); check("R6 third byte nack", {31'd0, a}, 32'd0);
    bus_stop;
    check("R4 reg10", {24'd0, reg_of(10)}, 32'h12);
    check("R4 reg11", {24'd0, reg_of(11)}, 32'h34);
    check("R6 reg12 kept", {24'd0, reg_of(12)}, 32'h44);
  endtask

  task automatic t_cmd_range;
    logic a;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd30, a);
    check("R5 block command 30 nack", {31'd0, a}, 32'd0);
    wbyte(8'd1, a); wbyte(8'hEE, a);
    bus_stop;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd151, a);
    check("R5 byte command 151 nack", {31'd0, a}, 32'd0);
    wbyte(8'hEE, a);
    bus_stop;
    check("R5 reg0 untouched", {24'd0, reg_of(0)}, 32'h00);
  endtask

  task automatic t_top_end;
    logic a;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd21, a); wbyte(8'd4, a);
    wbyte(8'hC1, a); wbyte(8'hC2, a);
    check("R6 reg22 byte ack", {31'd0, a}, 32'd1);
    wbyte(8'hC3, a); check("R6 past last register nack", {31'd0, a}, 32'd0);
    bus_stop;
    check("R6 reg21", {24'd0, reg_of(21)}, 32'hC1);
    check("R6 reg22", {24'd0, reg_of(22)}, 32'hC2);
  endtask

  task automatic t_fixed_bits;
    logic a;
    logic [7:0] d;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd129, a); wbyte(8'hFF, a);
    bus_stop;
    check("R9 reg1 merged view", {24'd0, reg_of(1)}, 32'hF6);
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd136, a); wbyte(8'hFF, a);
    bus_stop;
    check("R9 reg8 write ignored", {24'd0, reg_of(8)}, 32'h5A);
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd129, a);
    bus_start;
    wbyte(8'hD3, a); rbyte(1'b0, d);
    bus_stop;
    check("R9 reg1 readback", {24'd0, d}, 32'hF6);
  endtask

  task automatic t_block_read;
    logic a;
    logic [7:0] d;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd5, a);
    bus_start;
    wbyte(8'hD3, a); check("R7 read address ack", {31'd0, a}, 32'd1);
    rbyte(1'b1, d); check("R7 returned count", {24'd0, d}, 32'd18);
    rbyte(1'b1, d); check("R7 data reg5", {24'd0, d}, 32'h11);
    rbyte(1'b1, d); check("R7 data reg6", {24'd0, d}, 32'h22);
    rbyte(1'b0, d); check("R7 data reg7", {24'd0, d}, 32'h33);
    bus_stop;
  endtask

  task automatic t_byte_word_read;
    logic a;
    logic [7:0] d;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd131, a);
    bus_start;
    wbyte(8'hD3, a);
    rbyte(1'b0, d); check("R8 byte read reg3", {24'd0, d}, 32'hA5);
    bus_stop;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd138, a);
    bus_start;
    wbyte(8'hD3, a);
    rbyte(1'b1, d); check("R8 word read reg10", {24'd0, d}, 32'h12);
    rbyte(1'b0, d); check("R8 word read reg11", {24'd0, d}, 32'h34);
    bus_stop;
  endtask

  task automatic t_abort;
    logic a;
    logic s;
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd142, a);
    bus_stop;
    check("R10 reg14 untouched", {24'd0, reg_of(14)}, 32'h00);
    bus_start;
    wbyte(8'hD2, a); wbyte(8'd15, a); wbyte(8'd3, a);
    wbyte(8'h71, a); wbyte(8'h72, a);
    for (int i = 0; i < 4; i++) bit_cycle(1'b1, s);
    bus_stop;
    check("R10 reg15 kept", {24'd0, reg_of(15)}, 32'h71);
    check("R10 reg16 kept", {24'd0, reg_of(16)}, 32'h72);
    check("R10 reg17 untouched", {24'd0, reg_of(17)}, 32'h00);
    bus_start;
    wbyte(8'hD3, a); check("R10 read without command nack", {31'd0, a}, 32'd0);
    bus_stop;
  endtask

  initial begin : watchdog
    tick(150000);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    stat[1*8 +: 8] = 8'h06;
    stat[8*8 +: 8] = 8'h5A;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset;
    t_byte_write;
    t_bad_addr;
    t_block_write;
    t_word_write;
    t_cmd_range;
    t_top_end;
    t_fixed_bits;
    t_block_read;
    t_byte_word_read;
    t_abort;
    check("R11 enable changes with clock high", hi_changes, 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule